// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Masked Match

This block is a fully associative translation buffer. Each entry maps a pair of adjacent virtual pages to two physical frames, an even one and an odd one. Every entry stores its own page mask. A mask bit set to one removes that virtual page bit from the compare, so one entry can cover a larger region. A global bit lets an entry match any address-space identifier. Each half of an entry carries its own frame number, 3-bit cache attribute, dirty bit and valid bit.

Two combinational ports search the table in parallel. The lookup port returns hit, the index and the packed contents of the matched entry. The probe port returns only hit and index. Software-visible maintenance uses three controls. An indexed write port loads one entry. A flush command clears the whole table. A replacement pointer shows the entry it currently names and can be stepped forward by one. The page walk and the fault decision sit outside this block.

Top module: `pairtlb`

## Requirements
- R1: An entry matches only when the request page number equals the stored page number in every bit position where the entry's mask bit is 0. Bits where the mask is 1 are not compared.
- R2: The stored identifier must equal the request identifier for a match, unless the entry's global bit is 1. A global entry matches any identifier.
- R3: When several entries match, the lookup port reports the lowest matching index and that entry's contents.
- R4: On a match the probe port gives `pr_hit`=1 and the lowest matching index. On a miss it gives `pr_hit`=0 and `pr_idx` all ones.
- R5: On a lookup miss, `lk_hit`=0, `lk_idx` is all ones, and `lk_mask`, `lk_hi`, `lk_even` and `lk_odd` are all zero.
- R6: A write with `wr_idx` below ENTRIES loads that entry at the rising edge. Lookups in the cycle of the write still see the old contents.
- R7: A write with `wr_idx` equal to or above ENTRIES changes no entry.
- R8: Flush clears every entry field to zero and sets the replacement pointer to 0 at the next edge. It takes priority over a write and an advance in the same cycle.
- R9: A half word is packed as {frame, attr[2:0], dirty, valid, global}. Global is bit 0, valid is bit 1, dirty is bit 2, attr is bits 5:3, and the frame starts at bit 6. The high word is {page number, identifier}, with the identifier in the low ASID_W bits.
- R10: `rp_idx` shows the replacement pointer, and `rp_mask`, `rp_hi`, `rp_even` and `rp_odd` show the entry it names. `rp_adv`=1 steps the pointer by one at the edge, wrapping from ENTRIES-1 to 0. Without `rp_adv` the pointer holds.
- R11: While `rst_n` is low, the table and the pointer take the same all-zero state that a flush produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear whole table and pointer |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W+1 | Target entry of the write |
| wr_mask | input | VPN_W | Page mask to store |
| wr_vpn | input | VPN_W | Page-pair number to store |
| wr_asid | input | ASID_W | Identifier to store |
| wr_global | input | 1 | Global bit to store |
| wr_pfn_even | input | PFN_W | Even frame |
| wr_attr_even | input | 3 | Even cache attribute |
| wr_dirty_even | input | 1 | Even dirty bit |
| wr_valid_even | input | 1 | Even valid bit |
| wr_pfn_odd | input | PFN_W | Odd frame |
| wr_attr_odd | input | 3 | Odd cache attribute |
| wr_dirty_odd | input | 1 | Odd dirty bit |
| wr_valid_odd | input | 1 | Odd valid bit |
| lk_vpn | input | VPN_W | Lookup page-pair number |
| lk_asid | input | ASID_W | Lookup identifier |
| lk_hit | output | 1 | Lookup matched |
| lk_idx | output | IDX_W | Matched index, all ones on miss |
| lk_mask | output | VPN_W | Matched entry mask |
| lk_hi | output | VPN_W+ASID_W | Matched high word |
| lk_even | output | PFN_W+6 | Matched even half word |
| lk_odd | output | PFN_W+6 | Matched odd half word |
| pr_vpn | input | VPN_W | Probe page-pair number |
| pr_asid | input | ASID_W | Probe identifier |
| pr_hit | output | 1 | Probe matched |
| pr_idx | output | IDX_W | Probe index, all ones on miss |
| rp_adv | input | 1 | Advance replacement pointer |
| rp_idx | output | IDX_W | Replacement pointer |
| rp_mask | output | VPN_W | Mask of entry at pointer |
| rp_hi | output | VPN_W+ASID_W | High word of entry at pointer |
| rp_even | output | PFN_W+6 | Even half word at pointer |
| rp_odd | output | PFN_W+6 | Odd half word at pointer |

## Verification
Lookup and probe results are due in the same cycle as their request. The bench therefore samples them one time unit after it changes the request, well away from any clock edge. Writes, flushes and pointer advances show only after one rising edge. Their effects are sampled at the following falling edge. The same-cycle case of R6 is sampled just before that edge, while the write is still pending.

// File: rtl/pairtlb_pkg.sv
package pairtlb_pkg;
   // Cache attribute width of each half
   localparam int ATTR_W = 3;
   // Bit positions inside a packed half word
   localparam int POS_G    = 0;
   localparam int POS_V    = 1;
   localparam int POS_D    = 2;
   localparam int POS_ATTR = 3;
   localparam int FLAG_W   = POS_ATTR + ATTR_W;
endpackage

// File: rtl/pairtlb_store.sv
module pairtlb_store
   import pairtlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 12,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 16,
   parameter int IW      = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               flush,
   input  logic                               wr_en,
   input  logic [IW-1:0]                      wr_idx,
   input  logic [VPN_W-1:0]                   wr_mask,
   input  logic [VPN_W-1:0]                   wr_vpn,
   input  logic [ASID_W-1:0]                  wr_asid,
   input  logic                               wr_global,
   input  logic [PFN_W-1:0]                   wr_pfn_even,
   input  logic [ATTR_W-1:0]                  wr_attr_even,
   input  logic                               wr_dirty_even,
   input  logic                               wr_valid_even,
   input  logic [PFN_W-1:0]                   wr_pfn_odd,
   input  logic [ATTR_W-1:0]                  wr_attr_odd,
   input  logic                               wr_dirty_odd,
   input  logic                               wr_valid_odd,
   output logic [ENTRIES-1:0][VPN_W-1:0]      st_mask,
   output logic [ENTRIES-1:0][VPN_W-1:0]      st_vpn,
   output logic [ENTRIES-1:0][ASID_W-1:0]     st_asid,
   output logic [ENTRIES-1:0]                 st_g,
   output logic [ENTRIES-1:0][PFN_W-1:0]      st_pfn_e,
   output logic [ENTRIES-1:0][ATTR_W-1:0]     st_attr_e,
   output logic [ENTRIES-1:0]                 st_d_e,
   output logic [ENTRIES-1:0]                 st_v_e,
   output logic [ENTRIES-1:0][PFN_W-1:0]      st_pfn_o,
   output logic [ENTRIES-1:0][ATTR_W-1:0]     st_attr_o,
   output logic [ENTRIES-1:0]                 st_d_o,
   output logic [ENTRIES-1:0]                 st_v_o
);
   // One register slice per entry. An index at or past ENTRIES selects no slice.
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic                sel;
      logic [VPN_W-1:0]    mask_q, vpn_q;
      logic [ASID_W-1:0]   asid_q;
      logic                g_q, de_q, ve_q, do_q, vo_q;
      logic [PFN_W-1:0]    pe_q, po_q;
      logic [ATTR_W-1:0]   ae_q, ao_q;

      assign sel = wr_en && (wr_idx == IW'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q <= '0; vpn_q <= '0; asid_q <= '0; g_q <= 1'b0;
            pe_q <= '0; ae_q <= '0; de_q <= 1'b0; ve_q <= 1'b0;
            po_q <= '0; ao_q <= '0; do_q <= 1'b0; vo_q <= 1'b0;
         end else if (flush) begin
            mask_q <= '0; vpn_q <= '0; asid_q <= '0; g_q <= 1'b0;
            pe_q <= '0; ae_q <= '0; de_q <= 1'b0; ve_q <= 1'b0;
            po_q <= '0; ao_q <= '0; do_q <= 1'b0; vo_q <= 1'b0;
         end else if (sel) begin
            mask_q <= wr_mask;
            vpn_q  <= wr_vpn;
            asid_q <= wr_asid;
            g_q    <= wr_global;
            pe_q   <= wr_pfn_even;
            ae_q   <= wr_attr_even;
            de_q   <= wr_dirty_even;
            ve_q   <= wr_valid_even;
            po_q   <= wr_pfn_odd;
            ao_q   <= wr_attr_odd;
            do_q   <= wr_dirty_odd;
            vo_q   <= wr_valid_odd;
         end
      end

      assign st_mask[e]   = mask_q;
      assign st_vpn[e]    = vpn_q;
      assign st_asid[e]   = asid_q;
      assign st_g[e]      = g_q;
      assign st_pfn_e[e]  = pe_q;
      assign st_attr_e[e] = ae_q;
      assign st_d_e[e]    = de_q;
      assign st_v_e[e]    = ve_q;
      assign st_pfn_o[e]  = po_q;
      assign st_attr_o[e] = ao_q;
      assign st_d_o[e]    = do_q;
      assign st_v_o[e]    = vo_q;
   end
endmodule

// File: rtl/pairtlb_match.sv
module pairtlb_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 12,
   parameter int ASID_W  = 8
) (
   input  logic [VPN_W-1:0]               req_vpn,
   input  logic [ASID_W-1:0]              req_asid,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  st_mask,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  st_vpn,
   input  logic [ENTRIES-1:0][ASID_W-1:0] st_asid,
   input  logic [ENTRIES-1:0]             st_g,
   output logic [ENTRIES-1:0]             hits
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      logic page_eq, id_eq;
      // Masked-out bits are forced equal
      assign page_eq = ((req_vpn ^ st_vpn[e]) & ~st_mask[e]) == '0;
      assign id_eq   = st_g[e] || (req_asid == st_asid[e]);
      assign hits[e] = page_eq && id_eq;
   end
endmodule

// File: rtl/pairtlb_prio.sv
module pairtlb_prio #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic [ENTRIES-1:0] hits,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   // Scan from the top down so that the lowest set bit is written last
   always_comb begin
      any = 1'b0;
      idx = '1;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (hits[e]) begin
            any = 1'b1;
            idx = IDX_W'(e);
         end
      end
   end
endmodule

// File: rtl/pairtlb_ptr.sv
module pairtlb_ptr #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   logic [IDX_W-1:0] nxt;

   // Power-of-two tables wrap by natural overflow; others need a compare
   if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_pow2
      assign nxt = ptr + 1'b1;
   end else begin : g_cmp
      localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
      assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (flush) ptr <= '0;
      else if (adv)   ptr <= nxt;
   end
endmodule

// File: rtl/pairtlb.sv
module pairtlb
   import pairtlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 12,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 16,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int IW     = IDX_W + 1,
   localparam int HI_W   = VPN_W + ASID_W,
   localparam int HALF_W = PFN_W + FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [VPN_W-1:0]  wr_mask,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PFN_W-1:0]  wr_pfn_even,
   input  logic [ATTR_W-1:0] wr_attr_even,
   input  logic              wr_dirty_even,
   input  logic              wr_valid_even,
   input  logic [PFN_W-1:0]  wr_pfn_odd,
   input  logic [ATTR_W-1:0] wr_attr_odd,
   input  logic              wr_dirty_odd,
   input  logic              wr_valid_odd,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [VPN_W-1:0]  lk_mask,
   output logic [HI_W-1:0]   lk_hi,
   output logic [HALF_W-1:0] lk_even,
   output logic [HALF_W-1:0] lk_odd,
   input  logic [VPN_W-1:0]  pr_vpn,
   input  logic [ASID_W-1:0] pr_asid,
   output logic              pr_hit,
   output logic [IDX_W-1:0]  pr_idx,
   input  logic              rp_adv,
   output logic [IDX_W-1:0]  rp_idx,
   output logic [VPN_W-1:0]  rp_mask,
   output logic [HI_W-1:0]   rp_hi,
   output logic [HALF_W-1:0] rp_even,
   output logic [HALF_W-1:0] rp_odd
);
   logic [ENTRIES-1:0][VPN_W-1:0]  st_mask, st_vpn;
   logic [ENTRIES-1:0][ASID_W-1:0] st_asid;
   logic [ENTRIES-1:0]             st_g, st_d_e, st_v_e, st_d_o, st_v_o;
   logic [ENTRIES-1:0][PFN_W-1:0]  st_pfn_e, st_pfn_o;
   logic [ENTRIES-1:0][ATTR_W-1:0] st_attr_e, st_attr_o;
   logic [ENTRIES-1:0]             lk_hits, pr_hits;
   logic [ENTRIES-1:0][HI_W-1:0]   ent_hi;
   logic [ENTRIES-1:0][HALF_W-1:0] ent_even, ent_odd;

   pairtlb_store #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .IW(IW)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_vpn(wr_vpn),
      .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_pfn_even(wr_pfn_even), .wr_attr_even(wr_attr_even),
      .wr_dirty_even(wr_dirty_even), .wr_valid_even(wr_valid_even),
      .wr_pfn_odd(wr_pfn_odd), .wr_attr_odd(wr_attr_odd),
      .wr_dirty_odd(wr_dirty_odd), .wr_valid_odd(wr_valid_odd),
      .st_mask(st_mask), .st_vpn(st_vpn), .st_asid(st_asid), .st_g(st_g),
      .st_pfn_e(st_pfn_e), .st_attr_e(st_attr_e), .st_d_e(st_d_e), .st_v_e(st_v_e),
      .st_pfn_o(st_pfn_o), .st_attr_o(st_attr_o), .st_d_o(st_d_o), .st_v_o(st_v_o)
   );

   // Independent compare arrays for the two search ports
   pairtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
      .req_vpn(lk_vpn), .req_asid(lk_asid), .st_mask(st_mask), .st_vpn(st_vpn),
      .st_asid(st_asid), .st_g(st_g), .hits(lk_hits)
   );

   pairtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_pr_match (
      .req_vpn(pr_vpn), .req_asid(pr_asid), .st_mask(st_mask), .st_vpn(st_vpn),
      .st_asid(st_asid), .st_g(st_g), .hits(pr_hits)
   );

   pairtlb_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_prio (
      .hits(lk_hits), .any(lk_hit), .idx(lk_idx)
   );

   pairtlb_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pr_prio (
      .hits(pr_hits), .any(pr_hit), .idx(pr_idx)
   );

   pairtlb_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .flush(flush), .adv(rp_adv), .ptr(rp_idx)
   );

   // Packed words per entry: {frame, attr, dirty, valid, global}
   for (genvar e = 0; e < ENTRIES; e++) begin : g_pack
      assign ent_hi[e]   = {st_vpn[e], st_asid[e]};
      assign ent_even[e] = {st_pfn_e[e], st_attr_e[e], st_d_e[e], st_v_e[e], st_g[e]};
      assign ent_odd[e]  = {st_pfn_o[e], st_attr_o[e], st_d_o[e], st_v_o[e], st_g[e]};
   end

   // Matched-entry readout, zero on miss
   always_comb begin
      lk_mask = '0;
      lk_hi   = '0;
      lk_even = '0;
      lk_odd  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (lk_hit && (lk_idx == IDX_W'(e))) begin
            lk_mask = st_mask[e];
            lk_hi   = ent_hi[e];
            lk_even = ent_even[e];
            lk_odd  = ent_odd[e];
         end
      end
   end

   // Entry named by the replacement pointer
   always_comb begin
      rp_mask = '0;
      rp_hi   = '0;
      rp_even = '0;
      rp_odd  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (rp_idx == IDX_W'(e)) begin
            rp_mask = st_mask[e];
            rp_hi   = ent_hi[e];
            rp_even = ent_even[e];
            rp_odd  = ent_odd[e];
         end
      end
   end
endmodule

// File: rtl/pairtlb_chk.sv
module pairtlb_chk
   import pairtlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 12,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 16,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int IW     = IDX_W + 1,
   localparam int HI_W   = VPN_W + ASID_W,
   localparam int HALF_W = PFN_W + FLAG_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              wr_en,
   input logic [IW-1:0]     wr_idx,
   input logic [VPN_W-1:0]  lk_vpn,
   input logic [ASID_W-1:0] lk_asid,
   input logic              lk_hit,
   input logic [IDX_W-1:0]  lk_idx,
   input logic [VPN_W-1:0]  lk_mask,
   input logic [HI_W-1:0]   lk_hi,
   input logic [HALF_W-1:0] lk_even,
   input logic [HALF_W-1:0] lk_odd,
   input logic [VPN_W-1:0]  pr_vpn,
   input logic [ASID_W-1:0] pr_asid,
   input logic              pr_hit,
   input logic [IDX_W-1:0]  pr_idx,
   input logic              rp_adv,
   input logic [IDX_W-1:0]  rp_idx,
   input logic [VPN_W-1:0]  rp_mask,
   input logic [HI_W-1:0]   rp_hi,
   input logic [HALF_W-1:0] rp_even,
   input logic [HALF_W-1:0] rp_odd
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   p_hit_masked_eq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (((lk_vpn ^ lk_hi[HI_W-1:ASID_W]) & ~lk_mask) == '0));

   p_asid_or_global_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !lk_even[POS_G]) |-> (lk_hi[ASID_W-1:0] == lk_asid));

   p_ports_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((lk_vpn == pr_vpn) && (lk_asid == pr_asid)) |-> ((lk_hit == pr_hit) && (lk_idx == pr_idx)));

   p_probe_miss_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pr_hit |-> (pr_idx == '1));

   p_miss_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> ((lk_mask == '0) && (lk_hi == '0) && (lk_even == '0) && (lk_odd == '0)));

   p_bad_write_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx >= IW'(ENTRIES)) && !flush && !rp_adv) |=>
      ($stable(rp_mask) && $stable(rp_hi) && $stable(rp_even) && $stable(rp_odd)));

   p_flush_ptr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (rp_idx == '0));

   p_adv_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_adv && !flush) |=>
      (rp_idx == (($past(rp_idx) == LAST) ? '0 : $past(rp_idx) + 1'b1)));

   p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rp_adv && !flush) |=> $stable(rp_idx));
endmodule

bind pairtlb pairtlb_chk #(
   .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
   .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_idx(lk_idx),
   .lk_mask(lk_mask), .lk_hi(lk_hi), .lk_even(lk_even), .lk_odd(lk_odd),
   .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_hit(pr_hit), .pr_idx(pr_idx),
   .rp_adv(rp_adv), .rp_idx(rp_idx), .rp_mask(rp_mask), .rp_hi(rp_hi),
   .rp_even(rp_even), .rp_odd(rp_odd)
);

// File: tb/pairtlb_bench.sv
module pairtlb_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ENTRIES = 8;
   localparam int VPN_W = 12;
   localparam int ASID_W = 8;
   localparam int PFN_W = 16;
   localparam int IDX_W = 3;
   localparam int IW = 4;
   localparam int NVEC = 14;

   typedef struct packed {
      logic [11:0] vpn;
      logic [7:0]  asid;
      logic        hit;
      logic [2:0]  idx;
   } vec_t;

   // Request, expected hit, expected index (all ones on miss)
   localparam vec_t VECS [NVEC] = '{
      '{12'h100, 8'h05, 1'b1, 3'd0},
      '{12'h100, 8'h06, 1'b0, 3'd7},
      '{12'h101, 8'h05, 1'b0, 3'd7},
      '{12'h200, 8'h07, 1'b1, 3'd1},
      '{12'h20F, 8'h07, 1'b1, 3'd1},
      '{12'h210, 8'h07, 1'b0, 3'd7},
      '{12'h205, 8'h07, 1'b1, 3'd1},
      '{12'h205, 8'h08, 1'b0, 3'd7},
      '{12'h300, 8'h00, 1'b1, 3'd2},
      '{12'h300, 8'hFF, 1'b1, 3'd2},
      '{12'h4A0, 8'h0A, 1'b1, 3'd4},
      '{12'h4A1, 8'h0A, 1'b0, 3'd7},
      '{12'h000, 8'h00, 1'b1, 3'd5},
      '{12'h000, 8'h01, 1'b0, 3'd7}
   };

   logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, wr_en = 1'b0, rp_adv = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [VPN_W-1:0] wr_mask = '0, wr_vpn = '0, lk_vpn = '0, pr_vpn = '0;
   logic [ASID_W-1:0] wr_asid = '0, lk_asid = '0, pr_asid = '0;
   logic wr_global = 0, wr_dirty_even = 0, wr_valid_even = 0, wr_dirty_odd = 0, wr_valid_odd = 0;
   logic [PFN_W-1:0] wr_pfn_even = '0, wr_pfn_odd = '0;
   logic [2:0] wr_attr_even = '0, wr_attr_odd = '0;
   logic lk_hit, pr_hit;
   logic [IDX_W-1:0] lk_idx, pr_idx, rp_idx;
   logic [VPN_W-1:0] lk_mask, rp_mask;
   logic [VPN_W+ASID_W-1:0] lk_hi, rp_hi;
   logic [PFN_W+5:0] lk_even, lk_odd, rp_even, rp_odd;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pairtlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_pairtlb (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_mask(wr_mask), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_pfn_even(wr_pfn_even), .wr_attr_even(wr_attr_even),
      .wr_dirty_even(wr_dirty_even), .wr_valid_even(wr_valid_even),
      .wr_pfn_odd(wr_pfn_odd), .wr_attr_odd(wr_attr_odd),
      .wr_dirty_odd(wr_dirty_odd), .wr_valid_odd(wr_valid_odd),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_mask(lk_mask), .lk_hi(lk_hi), .lk_even(lk_even), .lk_odd(lk_odd),
      .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_hit(pr_hit), .pr_idx(pr_idx),
      .rp_adv(rp_adv), .rp_idx(rp_idx), .rp_mask(rp_mask), .rp_hi(rp_hi),
      .rp_even(rp_even), .rp_odd(rp_odd)
   );

   function automatic logic [PFN_W+5:0] half(input logic [PFN_W-1:0] pfn, input logic [2:0] attr,
                                             input logic d, input logic v, input logic g);
      return {pfn, attr, d, v, g};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [IW-1:0] idx, input logic [11:0] mask, input logic [11:0] vpn,
                      input logic [7:0] asid, input logic g, input logic [15:0] pe,
                      input logic [2:0] ae, input logic de, input logic ve, input logic [15:0] po,
                      input logic [2:0] ao, input logic dO, input logic vo);
      wr_en = 1'b1; wr_idx = idx; wr_mask = mask; wr_vpn = vpn; wr_asid = asid; wr_global = g;
      wr_pfn_even = pe; wr_attr_even = ae; wr_dirty_even = de; wr_valid_even = ve;
      wr_pfn_odd = po; wr_attr_odd = ao; wr_dirty_odd = dO; wr_valid_odd = vo;
   endtask

   task automatic write_entry(input logic [IW-1:0] idx, input logic [11:0] mask, input logic [11:0] vpn,
                              input logic [7:0] asid, input logic g, input logic [15:0] pe,
                              input logic [2:0] ae, input logic de, input logic ve, input logic [15:0] po,
                              input logic [2:0] ao, input logic dO, input logic vo);
      @(negedge clk);
      put(idx, mask, vpn, asid, g, pe, ae, de, ve, po, ao, dO, vo);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic look(input logic [11:0] vpn, input logic [7:0] asid);
      lk_vpn = vpn; lk_asid = asid; pr_vpn = vpn; pr_asid = asid;
      #1;
   endtask

   task automatic step_ptr();
      @(negedge clk);
      rp_adv = 1'b1;
      @(negedge clk);
      rp_adv = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state equals the flushed state
      look(12'h000, 8'h00);
      chk("R11 reset zero entry hit", {lk_hit, lk_idx}, {1'b1, 3'd0});
      chk("R11 reset zero entry words", {lk_hi, lk_even, lk_odd}, '0);
      chk("R11 reset pointer", rp_idx, 0);
      rst_n = 1'b1;
      look(12'h123, 8'h00);
      chk("R11 R5 nonzero page misses", {lk_hit, lk_idx}, {1'b0, 3'd7});

      write_entry(0, 12'h000, 12'h100, 8'h05, 1'b0, 16'h1111, 3'd3, 1'b1, 1'b1, 16'h2222, 3'd2, 1'b0, 1'b1);
      write_entry(1, 12'h00F, 12'h200, 8'h07, 1'b0, 16'h0A0A, 3'd1, 1'b0, 1'b1, 16'h0B0B, 3'd1, 1'b1, 1'b0);
      write_entry(2, 12'h000, 12'h300, 8'h09, 1'b1, 16'h3333, 3'd7, 1'b1, 1'b0, 16'h4444, 3'd0, 1'b0, 1'b0);
      write_entry(3, 12'h000, 12'h205, 8'h07, 1'b0, 16'h5555, 3'd5, 1'b1, 1'b1, 16'h6666, 3'd5, 1'b1, 1'b1);
      write_entry(4, 12'h0F0, 12'h400, 8'h0A, 1'b0, 16'h7777, 3'd4, 1'b0, 1'b0, 16'h8888, 3'd6, 1'b1, 1'b1);

      // R9: field packing of read-out words
      look(12'h100, 8'h05);
      chk("R9 high word", lk_hi, {12'h100, 8'h05});
      chk("R9 even half", lk_even, half(16'h1111, 3'd3, 1'b1, 1'b1, 1'b0));
      chk("R9 odd half", lk_odd, half(16'h2222, 3'd2, 1'b0, 1'b1, 1'b0));
      look(12'h300, 8'h42);
      chk("R9 R2 global bit in both halves", {lk_even[0], lk_odd[0]}, 2'b11);
      look(12'h4A0, 8'h0A);
      chk("R9 mask readout", lk_mask, 12'h0F0);

      // R1 R2 R3 R4 R5: vector table on both search ports
      for (int i = 0; i < NVEC; i++) begin
         look(VECS[i].vpn, VECS[i].asid);
         chk($sformatf("R1 R2 R3 R5 lookup vec %0d", i), {lk_hit, lk_idx}, {VECS[i].hit, VECS[i].idx});
         chk($sformatf("R4 probe vec %0d", i), {pr_hit, pr_idx}, {VECS[i].hit, VECS[i].idx});
         if (!VECS[i].hit)
            chk($sformatf("R5 miss words vec %0d", i), {lk_mask, lk_hi, lk_even, lk_odd}, '0);
      end
      look(12'h205, 8'h07);
      chk("R3 overlap returns lower entry words", lk_even, half(16'h0A0A, 3'd1, 1'b0, 1'b1, 1'b0));

      // R6: write visible only after the edge
      @(negedge clk);
      put(6, 12'h000, 12'h777, 8'h01, 1'b0, 16'h9999, 3'd2, 1'b1, 1'b1, 16'hAAAA, 3'd2, 1'b1, 1'b1);
      look(12'h777, 8'h01);
      chk("R6 same-cycle lookup sees old", lk_hit, 1'b0);
      @(negedge clk);
      wr_en = 1'b0;
      look(12'h777, 8'h01);
      chk("R6 written entry hit", {lk_hit, lk_idx}, {1'b1, 3'd6});

      // R7: out-of-range writes ignored
      write_entry(8, 12'h000, 12'h888, 8'h02, 1'b1, 16'hDEAD, 3'd1, 1'b1, 1'b1, 16'hBEEF, 3'd1, 1'b1, 1'b1);
      write_entry(15, 12'h000, 12'h889, 8'h02, 1'b1, 16'hDEAD, 3'd1, 1'b1, 1'b1, 16'hBEEF, 3'd1, 1'b1, 1'b1);
      look(12'h888, 8'h02);
      chk("R7 index 8 not stored", lk_hit, 1'b0);
      look(12'h889, 8'h02);
      chk("R7 index 15 not stored", lk_hit, 1'b0);
      look(12'h100, 8'h05);
      chk("R7 entry 0 unchanged", {lk_hit, lk_idx, lk_even}, {1'b1, 3'd0, half(16'h1111, 3'd3, 1'b1, 1'b1, 1'b0)});
      look(12'h000, 8'h00);
      chk("R7 entry 5 still zero", {lk_hit, lk_idx}, {1'b1, 3'd5});

      // R10: pointer readout, advance and wrap
      chk("R10 pointer entry readout", {rp_idx, rp_hi}, {3'd0, 12'h100, 8'h05});
      step_ptr();
      chk("R10 advance by one", {rp_idx, rp_hi, rp_mask}, {3'd1, 12'h200, 8'h07, 12'h00F});
      for (int k = 0; k < 6; k++) step_ptr();
      chk("R10 last entry", rp_idx, 3'd7);
      step_ptr();
      chk("R10 wrap to zero", rp_idx, 3'd0);
      @(negedge clk);
      @(negedge clk);
      chk("R10 hold without advance", rp_idx, 3'd0);
      for (int k = 0; k < 3; k++) step_ptr();
      chk("R10 pointer at three", {rp_idx, rp_even}, {3'd3, half(16'h5555, 3'd5, 1'b1, 1'b1, 1'b0)});

      // R8: flush wins over same-cycle write and advance
      @(negedge clk);
      put(2, 12'h000, 12'h999, 8'h03, 1'b0, 16'h1234, 3'd1, 1'b1, 1'b1, 16'h5678, 3'd1, 1'b1, 1'b1);
      flush = 1'b1;
      rp_adv = 1'b1;
      @(negedge clk);
      flush = 1'b0; rp_adv = 1'b0; wr_en = 1'b0;
      chk("R8 pointer cleared", rp_idx, 3'd0);
      chk("R8 pointer entry cleared", {rp_mask, rp_hi, rp_even, rp_odd}, '0);
      look(12'h999, 8'h03);
      chk("R8 same-cycle write dropped", lk_hit, 1'b0);
      look(12'h100, 8'h05);
      chk("R8 old entry gone", lk_hit, 1'b0);
      look(12'h000, 8'h00);
      chk("R8 cleared table matches zero at index 0", {lk_hit, lk_idx, lk_even}, {1'b1, 3'd0, 22'h0});

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule